// File: doc/BRIEF.md
# Deep Under-voltage Shutdown Controller

This controller protects a battery pack from being drained too far. An external comparator reports whether the pack voltage is below a programmed level. When that indication stays active for longer than a programmable delay, the controller turns off the charge, precharge and discharge FET enables and requests power-off. A warning interrupt flag is raised a fixed number of slow ticks before the shutdown, so software has time to save its state.

Once off, the controller ignores the voltage indication. It waits for a charger-present input and then issues a one-cycle restart request, returning every register to its default value. One configuration register holds the delay code and the detection-level code. The level code drives the external reference. A lock bit blocks further configuration writes until the next hardware reset.

Top module: `uv_shutdown_ctrl`

## Requirements
- R1: After hardware reset, all three FET enables are 1, `pwr_off`, `restart`, `warn_flag` and `cfg_locked` are 0, and `cfg_q` equals `CFG_RST`.
- R2: The timeout is (D+1)·STEP_TICKS ticks, where D is `cfg_q[3:0]`. The count advances on each `tick` pulse while `uv_low` is 1. On the tick that reaches the timeout, all FET enables drop to 0 and `pwr_off` rises, visible the cycle after that tick is sampled.
- R3: When the timeout exceeds WARN_TICKS, `warn_flag` sets on the tick at which the count reaches the timeout minus WARN_TICKS.
- R4: When the timeout is WARN_TICKS or less, the warning point clamps to zero and `warn_flag` sets on the first tick of the low episode.
- R5: If `uv_low` drops before the timeout, the count and `warn_flag` clear, and a later low episode needs the full timeout again.
- R6: While off, `uv_low` has no effect and the block stays off.
- R7: In the off state, `chg_det` produces a one-cycle `restart` pulse, re-enables the FETs, and resets `cfg_q`, the lock and the flag to their defaults. `chg_det` has no effect while running.
- R8: A `cfg_wr` stores `cfg_wdata` into `cfg_q`. Bits [3:0] are the delay code and bits [7:4] are the level code, which appears on `uv_level`.
- R9: After `lock_set`, `cfg_locked` is 1 and configuration writes are ignored until hardware reset.
- R10: A `flag_clr` pulse clears `warn_flag`, and the flag does not set again within the same low episode. If a set and a clear fall in the same cycle, the set wins.
- R11: `irq` is 1 exactly when `warn_flag` and `irq_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low |
| tick | input | 1 | Slow time-base pulse, one cycle wide |
| uv_low | input | 1 | Comparator output: pack below level |
| chg_det | input | 1 | Charger present |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| lock_set | input | 1 | Set configuration lock |
| flag_clr | input | 1 | Write-one clear of the warning flag |
| irq_en | input | 1 | Interrupt enable |
| cfg_q | output | 8 | Configuration register contents |
| uv_level | output | 4 | Detection-level code to the reference |
| cfg_locked | output | 1 | Lock state |
| cfet_en | output | 1 | Charge FET enable |
| pcfet_en | output | 1 | Precharge FET enable |
| dfet_en | output | 1 | Discharge FET enable |
| pwr_off | output | 1 | Power-off request |
| warn_flag | output | 1 | Early-warning flag |
| irq | output | 1 | Interrupt request |
| restart | output | 1 | Power-up restart pulse |

## Verification
The bench builds the block with STEP_TICKS=4 and WARN_TICKS=10, so timeouts range from 4 to 64 ticks. With these values, delay codes 0 to 1 fall into the clamped warning case and code 5 gives an unclamped warning at tick 14 of 24. Both warning regimes, the abort path and a full shutdown-and-restart cycle can therefore be reached in a few hundred ticks.

// File: rtl/uv_shutdown_ctrl.sv
module uv_shutdown_ctrl #(
  parameter int DLY_W      = 4,
  parameter int LVL_W      = 4,
  parameter int STEP_TICKS = 250,
  parameter int WARN_TICKS = 250,
  parameter int CFG_RST    = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   uv_low,
  input  logic                   chg_det,
  input  logic                   cfg_wr,
  input  logic [DLY_W+LVL_W-1:0] cfg_wdata,
  input  logic                   lock_set,
  input  logic                   flag_clr,
  input  logic                   irq_en,
  output logic [DLY_W+LVL_W-1:0] cfg_q,
  output logic [LVL_W-1:0]       uv_level,
  output logic                   cfg_locked,
  output logic                   cfet_en,
  output logic                   pcfet_en,
  output logic                   dfet_en,
  output logic                   pwr_off,
  output logic                   warn_flag,
  output logic                   irq,
  output logic                   restart
);
  localparam int CFG_W  = DLY_W + LVL_W;
  localparam int MAX_TO = (2 ** DLY_W) * STEP_TICKS;
  localparam int CNT_W  = $clog2(MAX_TO + WARN_TICKS + 1);

  logic [CNT_W-1:0] cnt, cnt_nx, timeout, warnpt;
  logic             off, warned, warn_hit;

  assign timeout  = (CNT_W'(cfg_q[DLY_W-1:0]) + CNT_W'(1)) * CNT_W'(STEP_TICKS);
  assign warnpt   = (timeout > CNT_W'(WARN_TICKS)) ? timeout - CNT_W'(WARN_TICKS) : '0;
  assign cnt_nx   = cnt + CNT_W'(1);
  assign warn_hit = !off && uv_low && tick && !warned && (cnt_nx >= warnpt);

  assign uv_level = cfg_q[CFG_W-1:DLY_W];
  assign cfet_en  = !off;
  assign pcfet_en = !off;
  assign dfet_en  = !off;
  assign pwr_off  = off;
  assign irq      = warn_flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= CFG_W'(CFG_RST);
      cfg_locked <= 1'b0;
      cnt        <= '0;
      off        <= 1'b0;
      warned     <= 1'b0;
      warn_flag  <= 1'b0;
      restart    <= 1'b0;
    end else begin
      restart <= 1'b0;
      if (cfg_wr && !cfg_locked) cfg_q <= cfg_wdata;
      if (lock_set) cfg_locked <= 1'b1;
      if (flag_clr) warn_flag <= 1'b0;
      if (!off) begin
        if (uv_low) begin
          if (tick) begin
            cnt <= cnt_nx;
            if (cnt_nx >= timeout) off <= 1'b1;
          end
          if (warn_hit) begin
            warn_flag <= 1'b1;
            warned    <= 1'b1;
          end
        end else begin
          cnt       <= '0;
          warned    <= 1'b0;
          warn_flag <= 1'b0;
        end
      end else if (chg_det) begin
        off        <= 1'b0;
        restart    <= 1'b1;
        cfg_q      <= CFG_W'(CFG_RST);
        cfg_locked <= 1'b0;
        cnt        <= '0;
        warned     <= 1'b0;
        warn_flag  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uv_shutdown_chk.sv
module uv_shutdown_chk #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             uv_low,
  input logic             chg_det,
  input logic [CFG_W-1:0] cfg_q,
  input logic             cfg_locked,
  input logic             pwr_off,
  input logic             warn_flag,
  input logic             restart
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  // R2
  off_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $rose(pwr_off)) |-> ($past(tick) && $past(uv_low)));

  // R6
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_off && !chg_det) |=> pwr_off);

  // R7
  restart_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && restart) |-> ($past(pwr_off) && $past(chg_det)));

  // R7
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && cfg_locked && $past(cfg_locked)) |-> $stable(cfg_q));

  // R3
  warn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $rose(warn_flag)) |-> $past(uv_low));

  // R5
  abort_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(uv_low) && !$past(pwr_off)) |-> !warn_flag);
endmodule

bind uv_shutdown_ctrl uv_shutdown_chk #(.CFG_W(DLY_W + LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .uv_low(uv_low), .chg_det(chg_det),
  .cfg_q(cfg_q), .cfg_locked(cfg_locked), .pwr_off(pwr_off),
  .warn_flag(warn_flag), .restart(restart)
);

// File: tb/sim_uv_shutdown_ctrl.sv
`timescale 1ns/1ps
module sim_uv_shutdown_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, uv_low = 0, chg_det = 0, cfg_wr = 0, lock_set = 0, flag_clr = 0, irq_en = 0;
  logic [7:0] cfg_wdata = 0;
  logic [7:0] cfg_q;
  logic [3:0] uv_level;
  logic cfg_locked, cfet_en, pcfet_en, dfet_en, pwr_off, warn_flag, irq, restart;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uv_shutdown_ctrl #(.DLY_W(4), .LVL_W(4), .STEP_TICKS(4), .WARN_TICKS(10), .CFG_RST(0)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .uv_low(uv_low), .chg_det(chg_det),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .lock_set(lock_set), .flag_clr(flag_clr),
    .irq_en(irq_en), .cfg_q(cfg_q), .uv_level(uv_level), .cfg_locked(cfg_locked),
    .cfet_en(cfet_en), .pcfet_en(pcfet_en), .dfet_en(dfet_en), .pwr_off(pwr_off),
    .warn_flag(warn_flag), .irq(irq), .restart(restart));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; step(); tick = 0; step();
    end
  endtask

  task automatic wr(logic [7:0] d);
    cfg_wdata = d; cfg_wr = 1; step(); cfg_wr = 0; step();
  endtask

  task automatic fets(string req, int exp);
    chk(req, {cfet_en, pcfet_en, dfet_en}, exp ? 7 : 0);
  endtask

  task automatic t_reset;
    fets("R1 fets", 1); chk("R1 pwr_off", pwr_off, 0); chk("R1 flag", warn_flag, 0);
    chk("R1 cfg", cfg_q, 0); chk("R1 lock", cfg_locked, 0); chk("R1 restart", restart, 0);
  endtask

  task automatic t_cfg;
    wr(8'hA5); chk("R8 cfg_q", cfg_q, 8'hA5); chk("R8 level", uv_level, 4'hA);
  endtask

  task automatic t_long;
    wr(8'h35); uv_low = 1; step();
    ticks(13); chk("R3 flag early", warn_flag, 0);
    ticks(1);  chk("R3 flag at 14", warn_flag, 1);
    irq_en = 1; step(); chk("R11 irq on", irq, 1);
    irq_en = 0; step(); chk("R11 irq off", irq, 0);
    ticks(9);  chk("R2 not yet off", pwr_off, 0); fets("R2 fets before", 1);
    ticks(1);  chk("R2 off at 24", pwr_off, 1); fets("R2 fets after", 0);
  endtask

  task automatic t_off_hold;
    uv_low = 0; ticks(5); chk("R6 stays off", pwr_off, 1); fets("R6 fets", 0);
    uv_low = 1; ticks(2); uv_low = 0; step(); chk("R6 still off", pwr_off, 1);
  endtask

  task automatic t_restart;
    lock_set = 1; step(); lock_set = 0; step();
    chg_det = 1; step(); chg_det = 0;
    chk("R7 restart pulse", restart, 1); chk("R7 on", pwr_off, 0); fets("R7 fets", 1);
    chk("R7 cfg default", cfg_q, 0); chk("R7 lock clear", cfg_locked, 0);
    chk("R7 flag clear", warn_flag, 0);
    step(); chk("R7 pulse ends", restart, 0);
  endtask

  task automatic t_abort;
    wr(8'h05); uv_low = 1; step(); ticks(16); chk("R5 flag set", warn_flag, 1);
    uv_low = 0; step(); chk("R5 flag cleared", warn_flag, 0);
    uv_low = 1; step(); ticks(13); chk("R5 count restarted", warn_flag, 0);
    ticks(10); chk("R5 no early off", pwr_off, 0);
    uv_low = 0; step();
  endtask

  task automatic t_clamp;
    wr(8'h01); uv_low = 1; step(); chk("R4 before tick", warn_flag, 0);
    ticks(1); chk("R4 first tick", warn_flag, 1);
    ticks(6); chk("R4 not off at 7", pwr_off, 0);
    ticks(1); chk("R4 off at 8", pwr_off, 1);
    uv_low = 0; chg_det = 1; step(); chg_det = 0; step();
  endtask

  task automatic t_w1c;
    wr(8'h05); uv_low = 1; step(); ticks(14); chk("R10 set", warn_flag, 1);
    flag_clr = 1; step(); flag_clr = 0; chk("R10 cleared", warn_flag, 0);
    ticks(2); chk("R10 no reset in episode", warn_flag, 0);
    uv_low = 0; step(); uv_low = 1; step(); ticks(13);
    tick = 1; flag_clr = 1; step(); tick = 0; flag_clr = 0; step();
    chk("R10 set wins", warn_flag, 1);
    uv_low = 0; step();
    chg_det = 1; step(); chg_det = 0;
    chk("R7 chg_det while running", restart, 0); chk("R7 cfg kept", cfg_q, 8'h05);
  endtask

  task automatic t_lock;
    wr(8'h35); lock_set = 1; step(); lock_set = 0; step();
    chk("R9 locked", cfg_locked, 1);
    wr(8'h77); chk("R9 write ignored", cfg_q, 8'h35);
    rst_n = 0; step(); rst_n = 1; step();
    chk("R9 reset unlocks", cfg_locked, 0); chk("R1 cfg after reset", cfg_q, 0);
    wr(8'h77); chk("R9 write after reset", cfg_q, 8'h77);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(3); rst_n = 1; step();
    t_reset(); t_cfg(); t_long(); t_off_hold(); t_restart();
    t_abort(); t_clamp(); t_w1c(); t_lock();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule